// File: doc/BRIEF.md
# Floating-Point Exception Flag and Mask Controller

This block keeps the control word and the status word of a floating-point pipeline. The control word holds one mask bit for each of six exception kinds and a two-bit rounding-mode field. The status word holds six sticky exception flags, an error summary bit and four condition bits. The datapath reports exceptions when an operation retires. Invalid operation, denormal operand and divide by zero are found before the arithmetic runs. Overflow, underflow and inexact result are found after it.

A masked exception only records its flag, because the datapath supplies a default result. An unmasked exception also raises the summary bit and a trap request for a software handler. When an operation has an unmasked pre-execution fault, its post-execution reports are discarded. An init command restores the default control word. A compare unit writes an encoded outcome into the condition bits. Three of those bits are also presented as integer carry, parity and zero flags for branch logic.

Top module: `fpx_ctrl`

## Requirements
- R1: After reset the control word reads 0x037F, the status word reads 0x0000 and trap_o is low.
- R2: init_i loads 0x037F into the control word on the next clock edge and wins over a control-word write in the same cycle. A lone cw_wr_i loads cw_wdata_i.
- R3: Flag and mask bits share positions: invalid bit 0, denormal bit 1, divide-by-zero bit 2, overflow bit 3, underflow bit 4, inexact bit 5. pre_exc_i is {Z,D,I} and post_exc_i is {P,U,O}. Both are accepted only while op_valid_i is high and are ignored otherwise.
- R4: A set flag stays set across later operations until a clear.
- R5: clr_i zeroes all six flags on the next edge and wins over exceptions reported in the same cycle.
- R6: Status bit 7 is the OR of the flags whose mask bit is clear. It follows later mask changes, and masked flags never set it.
- R7: trap_o is high exactly when status bit 7 is high. It can only rise after an operation or a control-word write.
- R8: If an operation reports a pre-execution exception whose mask is clear, its post-execution exceptions set no flag. A masked pre-execution exception does not suppress them.
- R9: A compare sets C3,C2,C0 to 000 for greater, 001 for less, 100 for equal and 111 for unordered. cmp_res_i codes are 00 greater, 01 less, 10 equal, 11 unordered. C0 is status bit 8, C1 is bit 9 and is cleared, C2 is bit 10, C3 is bit 14. The bits hold until the next compare.
- R10: cf_o equals C0, pf_o equals C2 and zf_o equals C3.
- R11: rc_o presents control word bits 11:10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Load default control word |
| cw_wr_i | input | 1 | Control word write strobe |
| cw_wdata_i | input | 16 | Control word write data |
| clr_i | input | 1 | Clear sticky exception flags |
| op_valid_i | input | 1 | Operation retires this cycle |
| pre_exc_i | input | 3 | Pre-execution exceptions {Z,D,I} |
| post_exc_i | input | 3 | Post-execution exceptions {P,U,O} |
| cmp_valid_i | input | 1 | Compare result valid |
| cmp_res_i | input | 2 | Compare outcome code |
| cw_o | output | 16 | Control word |
| sw_o | output | 16 | Status word |
| rc_o | output | 2 | Rounding mode field |
| trap_o | output | 1 | Software handler request |
| cf_o | output | 1 | Carry flag view of C0 |
| pf_o | output | 1 | Parity flag view of C2 |
| zf_o | output | 1 | Zero flag view of C3 |

## Verification
Exceptions are reported first under the fully masked default, where flags must appear with no trap. They are then reported with a single mask bit cleared, which separates flag recording from trap generation. Operations that carry both a pre-execution and a post-execution report are run once with the pre fault unmasked and once with it masked, so that wrong suppression in either direction shows. All four compare codes are applied, because each one drives a distinct pattern of C0, C2 and C3. Simultaneous clear/exception and init/write cycles check the stated priorities.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int CW_W    = 16;
    localparam int SW_W    = 16;
    localparam int EXC_N   = 6;
    localparam int PRE_N   = 3;
    localparam int POST_N  = EXC_N - PRE_N;
    localparam int RC_W    = 2;
    localparam int RC_LSB  = 10;
    localparam int SUM_BIT = 7;
    localparam int C0_BIT  = 8;
    localparam int C1_BIT  = 9;
    localparam int C2_BIT  = 10;
    localparam int C3_BIT  = 14;
    localparam logic [CW_W-1:0] CW_INIT = 16'h037F;

    typedef enum logic [1:0] {
        CMP_GT = 2'b00,
        CMP_LT = 2'b01,
        CMP_EQ = 2'b10,
        CMP_UN = 2'b11
    } cmp_res_e;

    typedef struct packed {
        logic c3;
        logic c2;
        logic c1;
        logic c0;
    } cond_t;
endpackage

// File: rtl/fpx_ctl_reg.sv
module fpx_ctl_reg
    import fpx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_i,
    input  logic            wr_i,
    input  logic [CW_W-1:0] wdata_i,
    output logic [CW_W-1:0] cw_o
);
    typedef struct packed {
        logic [CW_W-1:0] cw;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (init_i) begin
            st_d.cw = CW_INIT;
        end else if (wr_i) begin
            st_d.cw = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cw <= CW_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign cw_o = st_q.cw;
endmodule

// File: rtl/fpx_flag_unit.sv
module fpx_flag_unit
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              op_valid_i,
    input  logic [PRE_N-1:0]  pre_exc_i,
    input  logic [POST_N-1:0] post_exc_i,
    input  logic [EXC_N-1:0]  mask_i,
    output logic [EXC_N-1:0]  flags_o,
    output logic              summary_o
);
    typedef struct packed {
        logic [EXC_N-1:0] flags;
    } flag_st_t;

    flag_st_t st_d, st_q;

    logic              pre_fault;
    logic [POST_N-1:0] post_kept;
    logic [EXC_N-1:0]  raised;
    logic [EXC_N-1:0]  unmasked;

    always_comb begin
        pre_fault = |(pre_exc_i & ~mask_i[PRE_N-1:0]);
        post_kept = pre_fault ? '0 : post_exc_i;
        raised    = op_valid_i ? {post_kept, pre_exc_i} : '0;
        st_d      = st_q;
        if (clr_i) begin
            st_d.flags = '0;
        end else begin
            st_d.flags = st_q.flags | raised;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 0; k < EXC_N; k++) begin : g_unmasked
        assign unmasked[k] = st_q.flags[k] & ~mask_i[k];
    end

    assign flags_o   = st_q.flags;
    assign summary_o = |unmasked;
endmodule

// File: rtl/fpx_cond_unit.sv
module fpx_cond_unit
    import fpx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmp_valid_i,
    input  cmp_res_e cmp_res_i,
    output cond_t    cond_o
);
    typedef struct packed {
        cond_t cc;
    } cond_st_t;

    cond_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmp_valid_i) begin
            st_d.cc = '0;
            unique case (cmp_res_i)
                CMP_GT: st_d.cc = '0;
                CMP_LT: st_d.cc.c0 = 1'b1;
                CMP_EQ: st_d.cc.c3 = 1'b1;
                CMP_UN: begin
                    st_d.cc.c3 = 1'b1;
                    st_d.cc.c2 = 1'b1;
                    st_d.cc.c0 = 1'b1;
                end
                default: st_d.cc = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cond_o = st_q.cc;
endmodule

// File: rtl/fpx_ctrl.sv
module fpx_ctrl
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              cw_wr_i,
    input  logic [CW_W-1:0]   cw_wdata_i,
    input  logic              clr_i,
    input  logic              op_valid_i,
    input  logic [PRE_N-1:0]  pre_exc_i,
    input  logic [POST_N-1:0] post_exc_i,
    input  logic              cmp_valid_i,
    input  logic [1:0]        cmp_res_i,
    output logic [CW_W-1:0]   cw_o,
    output logic [SW_W-1:0]   sw_o,
    output logic [RC_W-1:0]   rc_o,
    output logic              trap_o,
    output logic              cf_o,
    output logic              pf_o,
    output logic              zf_o
);
    logic [CW_W-1:0]  cw;
    logic [EXC_N-1:0] flags;
    logic             summary;
    cond_t            cond;

    fpx_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (init_i),
        .wr_i    (cw_wr_i),
        .wdata_i (cw_wdata_i),
        .cw_o    (cw)
    );

    fpx_flag_unit u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_i),
        .op_valid_i (op_valid_i),
        .pre_exc_i  (pre_exc_i),
        .post_exc_i (post_exc_i),
        .mask_i     (cw[EXC_N-1:0]),
        .flags_o    (flags),
        .summary_o  (summary)
    );

    fpx_cond_unit u_cond (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_valid_i (cmp_valid_i),
        .cmp_res_i   (cmp_res_e'(cmp_res_i)),
        .cond_o      (cond)
    );

    always_comb begin
        sw_o               = '0;
        sw_o[EXC_N-1:0]    = flags;
        sw_o[SUM_BIT]      = summary;
        sw_o[C0_BIT]       = cond.c0;
        sw_o[C1_BIT]       = cond.c1;
        sw_o[C2_BIT]       = cond.c2;
        sw_o[C3_BIT]       = cond.c3;
    end

    assign cw_o   = cw;
    assign rc_o   = cw[RC_LSB +: RC_W];
    assign trap_o = summary;
    assign cf_o   = cond.c0;
    assign pf_o   = cond.c2;
    assign zf_o   = cond.c3;
endmodule

// File: rtl/fpx_ctrl_chk.sv
module fpx_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        init_i,
    input logic        cw_wr_i,
    input logic        clr_i,
    input logic        op_valid_i,
    input logic [2:0]  pre_exc_i,
    input logic        cmp_valid_i,
    input logic [1:0]  cmp_res_i,
    input logic [15:0] cw_o,
    input logic [15:0] sw_o,
    input logic        trap_o,
    input logic        cf_o,
    input logic        pf_o,
    input logic        zf_o
);
    assert_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (cw_o == 16'h037F));

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((sw_o[5:0] & $past(sw_o[5:0])) == $past(sw_o[5:0])));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sw_o[5:0] == 6'd0));

    assert_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sw_o[7] == |(sw_o[5:0] & ~cw_o[5:0]));

    assert_trap_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_o) |-> $past(op_valid_i || cw_wr_i));

    assert_suppress_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !clr_i && ((pre_exc_i & ~cw_o[2:0]) != 3'd0))
        |=> (sw_o[5:3] == $past(sw_o[5:3])));

    assert_unordered_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid_i && cmp_res_i == 2'b11) |=> (sw_o[14] && sw_o[10] && sw_o[8] && !sw_o[9]));

    assert_cond_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid_i |=> $stable({sw_o[14], sw_o[10:8]}));

    assert_intflags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_o == sw_o[8]) && (pf_o == sw_o[10]) && (zf_o == sw_o[14]));
endmodule

bind fpx_ctrl fpx_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (init_i),
    .cw_wr_i     (cw_wr_i),
    .clr_i       (clr_i),
    .op_valid_i  (op_valid_i),
    .pre_exc_i   (pre_exc_i),
    .cmp_valid_i (cmp_valid_i),
    .cmp_res_i   (cmp_res_i),
    .cw_o        (cw_o),
    .sw_o        (sw_o),
    .trap_o      (trap_o),
    .cf_o        (cf_o),
    .pf_o        (pf_o),
    .zf_o        (zf_o)
);

// File: tb/fpx_ctrl_tb.sv
module fpx_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 1'b0;
    logic        cw_wr_i = 1'b0;
    logic [15:0] cw_wdata_i = '0;
    logic        clr_i = 1'b0;
    logic        op_valid_i = 1'b0;
    logic [2:0]  pre_exc_i = '0;
    logic [2:0]  post_exc_i = '0;
    logic        cmp_valid_i = 1'b0;
    logic [1:0]  cmp_res_i = '0;
    logic [15:0] cw_o;
    logic [15:0] sw_o;
    logic [1:0]  rc_o;
    logic        trap_o;
    logic        cf_o;
    logic        pf_o;
    logic        zf_o;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    fpx_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .cw_wr_i(cw_wr_i),
        .cw_wdata_i(cw_wdata_i), .clr_i(clr_i), .op_valid_i(op_valid_i),
        .pre_exc_i(pre_exc_i), .post_exc_i(post_exc_i), .cmp_valid_i(cmp_valid_i),
        .cmp_res_i(cmp_res_i), .cw_o(cw_o), .sw_o(sw_o), .rc_o(rc_o),
        .trap_o(trap_o), .cf_o(cf_o), .pf_o(pf_o), .zf_o(zf_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        init_i = 0; cw_wr_i = 0; cw_wdata_i = '0; clr_i = 0; op_valid_i = 0;
        pre_exc_i = '0; post_exc_i = '0; cmp_valid_i = 0; cmp_res_i = '0;
    endtask

    task automatic finish_cycle();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_op(input logic v, input logic [2:0] pre, input logic [2:0] post);
        op_valid_i = v; pre_exc_i = pre; post_exc_i = post;
        finish_cycle();
    endtask

    task automatic do_clr();
        clr_i = 1; finish_cycle();
    endtask

    task automatic do_wr(input logic [15:0] v);
        cw_wr_i = 1; cw_wdata_i = v; finish_cycle();
    endtask

    task automatic do_cmp(input logic [1:0] r);
        cmp_valid_i = 1; cmp_res_i = r; finish_cycle();
    endtask

    task automatic t_reset();
        chk("R1 cw", cw_o, 16'h037F);
        chk("R1 sw", sw_o, 16'h0000);
        chk("R1 trap", {15'd0, trap_o}, 16'd0);
        chk("R11 rc reset", {14'd0, rc_o}, 16'd0);
    endtask

    task automatic t_masked();
        do_op(1, 3'b001, 3'b100);
        chk("R3 masked flags", sw_o, 16'h0021);
        chk("R6 masked no trap", {15'd0, trap_o}, 16'd0);
        do_op(1, 3'b000, 3'b000);
        chk("R4 sticky", sw_o, 16'h0021);
        do_op(0, 3'b110, 3'b011);
        chk("R3 ignored without op_valid", sw_o, 16'h0021);
        do_clr();
        chk("R5 clear", sw_o, 16'h0000);
        clr_i = 1; do_op(1, 3'b111, 3'b111);
        chk("R5 clear wins", sw_o, 16'h0000);
    endtask

    task automatic t_unmask();
        do_wr(16'h037E);
        chk("R2 write", cw_o, 16'h037E);
        do_op(1, 3'b001, 3'b000);
        chk("R6 unmasked summary", sw_o, 16'h0081);
        chk("R7 trap high", {15'd0, trap_o}, 16'd1);
        do_wr(16'h037F);
        chk("R6 remask drops summary", sw_o, 16'h0001);
        chk("R7 trap low", {15'd0, trap_o}, 16'd0);
    endtask

    task automatic t_suppress();
        do_clr();
        do_wr(16'h037E);
        do_op(1, 3'b001, 3'b001);
        chk("R8 unmasked pre suppresses post", sw_o, 16'h0081);
        do_clr();
        do_wr(16'h037F);
        do_op(1, 3'b001, 3'b001);
        chk("R8 masked pre keeps post", sw_o, 16'h0009);
        do_clr();
    endtask

    task automatic t_ctl();
        init_i = 1; do_wr(16'h0C00);
        chk("R2 init wins", cw_o, 16'h037F);
        do_wr(16'h0C00);
        chk("R2 plain write", cw_o, 16'h0C00);
        chk("R11 rc field", {14'd0, rc_o}, 16'd3);
        init_i = 1; finish_cycle();
        chk("R2 init", cw_o, 16'h037F);
    endtask

    task automatic t_cmp();
        do_cmp(2'b01);
        chk("R9 less", sw_o, 16'h0100);
        chk("R10 less flags", {13'd0, cf_o, pf_o, zf_o}, 16'b100);
        do_cmp(2'b10);
        chk("R9 equal", sw_o, 16'h4000);
        chk("R10 equal flags", {13'd0, cf_o, pf_o, zf_o}, 16'b001);
        do_cmp(2'b11);
        chk("R9 unordered", sw_o, 16'h4500);
        chk("R10 unordered flags", {13'd0, cf_o, pf_o, zf_o}, 16'b111);
        do_op(1, 3'b000, 3'b000);
        chk("R9 hold", sw_o, 16'h4500);
        do_cmp(2'b00);
        chk("R9 greater", sw_o, 16'h0000);
        chk("R10 greater flags", {13'd0, cf_o, pf_o, zf_o}, 16'b000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_masked();
        t_unmask();
        t_suppress();
        t_ctl();
        t_cmp();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule